// File: doc/BRIEF.md
# Programmable-Depth Bit Elastic Store

This block is a one-bit-wide circular buffer placed between a jittery serial clock domain and a smoothed output clock domain. Bits enter on the write clock and leave on the read clock when the read strobe is high. A direction input picks which of two clock/data pairs feeds the write side: the receive-line pair or the transmit pair. A 3-bit size code selects the usable depth at run time, from 8 up to 128 bits.

The fill level is the write count minus the read count, measured in bits. It is published in the read domain as a phase-error word, and an external clock-smoothing loop uses it to steer the read clock. A centering command seeds the pointers so the buffer sits half full. The margin is then equal in both directions, which gives 64 bits each way at the 128-bit depth.

When the buffer runs full or empty, the block raises a sticky limit-error flag. A separate status bit records which of the two limits was hit last. Pointers cross between the domains in Gray code through two-flop synchronizers. The sticky flag clears only on a dedicated clear pulse.

Top module: `bit_elastic_store`

## Requirements
- R1: The size code `size_sel` maps to a depth as follows: codes 0, 1, 2, 3 and 4 give 8, 16, 32, 64 and 128 bits, and codes 5, 6 and 7 give 128 bits. The depth is the largest fill the store accepts before it refuses writes.
- R2: Bits are read out in the order they were written. The write and read addresses wrap modulo the selected depth.
- R3: While `center` is high, the read address is forced to half the selected depth, and `limit_full` is cleared. Limit events that arrive during this time are ignored. The write side then restarts its address at zero, three write-clock edges after it sees `center`. After `center` is released and both sides have settled, `phase_err` equals half the depth.
- R4: `phase_err` is an unsigned count from 0 to the depth. It equals the bits written minus the bits read, and it is registered in the read-clock domain.
- R5: A write while the store holds `depth` bits is discarded. It then sets `limit_err` to 1 and `limit_full` to 1, and `phase_err` stays at the depth.
- R6: A read strobe while the store is empty leaves `rd_dat` unchanged, so the last bit repeats. It also sets `limit_err` to 1 and clears `limit_full` to 0 (0 means the last limit was empty).
- R7: `limit_err` stays at 1 until a one-cycle `err_clr` pulse on the read clock clears it. Neither `center` nor later normal traffic clears it.
- R8: With `dir_tx`=0, `rx_clk`/`rx_dat` drive the write side. With `dir_tx`=1, `tx_clk`/`tx_dat` drive it. Edges and data on the unselected pair have no effect.
- R9: After a synchronous reset, `rd_dat`, `phase_err`, `limit_err` and `limit_full` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| rx_clk | input | 1 | Receive-line write clock |
| rx_dat | input | 1 | Receive-line serial data |
| tx_clk | input | 1 | Transmit write clock |
| tx_dat | input | 1 | Transmit serial data |
| dir_tx | input | 1 | Write-source select: 0 receive pair, 1 transmit pair |
| rd_clk | input | 1 | Smoothed output (read) clock |
| rd_en | input | 1 | Read strobe, one bit per asserted edge |
| size_sel | input | 3 | Depth code |
| center | input | 1 | Re-centering command (read domain, level) |
| err_clr | input | 1 | Clear pulse for the sticky limit-error flag |
| rd_dat | output | 1 | Registered output bit |
| phase_err | output | MAX_LOG+1 | Fill level in bits |
| limit_err | output | 1 | Sticky overflow/underrun flag |
| limit_full | output | 1 | Last limit event: 1 full, 0 empty |

## Verification
The bench keeps the default `MAX_LOG` of 7, so every size code from 0 to 7 is reachable, including the three codes that clip to 128. For each code it alternates the write pair, centers the store, fills it exactly to the top, forces one overflow, drains it bit by bit and forces one underrun. The expected depth, fill levels and bit pattern are all computed arithmetically. Decoy edges on the unselected pair run through every fill, so any leak shows up as an off-by-one fill level or an inverted data bit.

// File: rtl/bes_pkg.sv
package bes_pkg;
  localparam int unsigned MIN_LOG  = 3;
  localparam int unsigned TOP_CODE = 4;

  // log2 of the depth selected by a size code, clipped to the build maximum
  function automatic int unsigned size_log2(input logic [2:0] code, input int unsigned max_log);
    int unsigned lg;
    if (code > 3'(TOP_CODE)) lg = MIN_LOG + TOP_CODE;
    else                     lg = MIN_LOG + 32'(code);
    if (lg > max_log) lg = max_log;
    return lg;
  endfunction
endpackage

// File: rtl/bes_sync.sv
module bes_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bes_gray_rx.sv
module bes_gray_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_a,
  output logic [W-1:0] bin
);
  logic [W-1:0] gray_s;

  bes_sync #(.W(W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (gray_a),
    .q   (gray_s)
  );

  always_comb begin
    for (int i = 0; i < W; i++) bin[i] = ^(gray_s >> i);
  end
endmodule

// File: rtl/bes_bitram.sv
module bes_bitram #(
  parameter int AW = 7
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          q
);
  localparam int DEPTH = 1 << AW;

  logic mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rst)     q <= 1'b0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/bes_wr.sv
module bes_wr
  import bes_pkg::*;
#(
  parameter int MAX_LOG = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               din,
  input  logic [2:0]         size_sel,
  input  logic               center_a,
  input  logic [MAX_LOG:0]   rd_gray_a,
  output logic [MAX_LOG:0]   wr_gray,
  output logic               ovf_tgl,
  output logic               we,
  output logic [MAX_LOG-1:0] waddr,
  output logic               wdata
);
  localparam int PW = MAX_LOG + 1;

  logic [PW-1:0]      wr_bin, wr_next, rd_bin, occ, depth_v;
  logic [MAX_LOG-1:0] mask;
  logic               cen_s, cen_d, rise, full;

  bes_gray_rx #(.W(PW)) u_rdptr (
    .clk    (clk),
    .rst    (rst),
    .gray_a (rd_gray_a),
    .bin    (rd_bin)
  );

  bes_sync #(.W(1)) u_cen (
    .clk (clk),
    .rst (rst),
    .d   (center_a),
    .q   (cen_s)
  );

  always_comb begin
    depth_v = PW'(1) << size_log2(size_sel, MAX_LOG);
    mask    = MAX_LOG'(depth_v - PW'(1));
    occ     = wr_bin - rd_bin;
    full    = (occ >= depth_v);
    rise    = cen_s & ~cen_d;
    wr_next = wr_bin + PW'(1);
    we      = ~rst & ~rise & ~full;
    waddr   = wr_bin[MAX_LOG-1:0] & mask;
    wdata   = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      ovf_tgl <= 1'b0;
      cen_d   <= 1'b0;
    end else begin
      cen_d <= cen_s;
      if (rise) begin
        wr_bin  <= '0;
        wr_gray <= '0;
      end else if (full) begin
        ovf_tgl <= ~ovf_tgl;
      end else begin
        wr_bin  <= wr_next;
        wr_gray <= wr_next ^ (wr_next >> 1);
      end
    end
  end

  // Pointer crossing must be safe: one bit per edge except when re-seeded (R2)
  assert_gray_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rise) |-> ($countones(wr_gray ^ $past(wr_gray)) <= 1));

  // A refused write must not move the published pointer (R5)
  assert_hold_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    (full && !rise) |=> $stable(wr_gray));
endmodule

// File: rtl/bes_rd.sv
module bes_rd
  import bes_pkg::*;
#(
  parameter int MAX_LOG = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [2:0]         size_sel,
  input  logic               center,
  input  logic               err_clr,
  input  logic [MAX_LOG:0]   wr_gray_a,
  input  logic               ovf_tgl_a,
  input  logic               rd_dat,
  output logic [MAX_LOG:0]   rd_gray,
  output logic               re,
  output logic [MAX_LOG-1:0] raddr,
  output logic [MAX_LOG:0]   phase_err,
  output logic               limit_err,
  output logic               limit_full
);
  localparam int PW = MAX_LOG + 1;

  logic [PW-1:0]      wr_bin, rd_bin, rd_next, occ, depth_v, seed;
  logic [MAX_LOG-1:0] mask;
  logic               tgl_s, tgl_d, ovf_ev, rd_req, empty, under;

  bes_gray_rx #(.W(PW)) u_wrptr (
    .clk    (clk),
    .rst    (rst),
    .gray_a (wr_gray_a),
    .bin    (wr_bin)
  );

  bes_sync #(.W(1)) u_ovf (
    .clk (clk),
    .rst (rst),
    .d   (ovf_tgl_a),
    .q   (tgl_s)
  );

  always_comb begin
    depth_v = PW'(1) << size_log2(size_sel, MAX_LOG);
    mask    = MAX_LOG'(depth_v - PW'(1));
    seed    = PW'(0) - (depth_v >> 1);
    occ     = wr_bin - rd_bin;
    empty   = (occ == '0);
    rd_req  = rd_en & ~center;
    re      = rd_req & ~empty & ~rst;
    under   = rd_req & empty;
    ovf_ev  = tgl_s ^ tgl_d;
    rd_next = rd_bin + PW'(1);
    raddr   = rd_bin[MAX_LOG-1:0] & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bin     <= '0;
      rd_gray    <= '0;
      tgl_d      <= 1'b0;
      phase_err  <= '0;
      limit_err  <= 1'b0;
      limit_full <= 1'b0;
    end else begin
      tgl_d     <= tgl_s;
      phase_err <= occ;
      if (center) begin
        rd_bin  <= seed;
        rd_gray <= seed ^ (seed >> 1);
      end else if (re) begin
        rd_bin  <= rd_next;
        rd_gray <= rd_next ^ (rd_next >> 1);
      end
      if (!center && (ovf_ev || under)) limit_err <= 1'b1;
      else if (err_clr)                 limit_err <= 1'b0;
      if (center)      limit_full <= 1'b0;
      else if (ovf_ev) limit_full <= 1'b1;
      else if (under)  limit_full <= 1'b0;
    end
  end

  // Underrun repeats the previous bit (R6)
  assert_repeat_on_underrun_R6: assert property (@(posedge clk) disable iff (rst)
    under |=> $stable(rd_dat));

  // Sticky flag survives everything but the clear pulse (R7)
  assert_sticky_err_R7: assert property (@(posedge clk) disable iff (rst)
    (limit_err && !err_clr) |=> limit_err);

  // Centering wipes the empty/full status (R3)
  assert_center_clears_status_R3: assert property (@(posedge clk) disable iff (rst)
    center |=> !limit_full);

  // A full status never appears without the sticky error (R5)
  assert_full_implies_err_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(limit_full) |-> limit_err);
endmodule

// File: rtl/bit_elastic_store.sv
module bit_elastic_store #(
  parameter int MAX_LOG = 7
) (
  input  logic             rst,
  input  logic             rx_clk,
  input  logic             rx_dat,
  input  logic             tx_clk,
  input  logic             tx_dat,
  input  logic             dir_tx,
  input  logic             rd_clk,
  input  logic             rd_en,
  input  logic [2:0]       size_sel,
  input  logic             center,
  input  logic             err_clr,
  output logic             rd_dat,
  output logic [MAX_LOG:0] phase_err,
  output logic             limit_err,
  output logic             limit_full
);
  logic               wr_clk, wr_din;
  logic [MAX_LOG:0]   wr_gray, rd_gray;
  logic               ovf_tgl, we, wdata, re;
  logic [MAX_LOG-1:0] waddr, raddr;

  always_comb begin
    wr_clk = dir_tx ? tx_clk : rx_clk;
    wr_din = dir_tx ? tx_dat : rx_dat;
  end

  bes_wr #(.MAX_LOG(MAX_LOG)) u_wr (
    .clk       (wr_clk),
    .rst       (rst),
    .din       (wr_din),
    .size_sel  (size_sel),
    .center_a  (center),
    .rd_gray_a (rd_gray),
    .wr_gray   (wr_gray),
    .ovf_tgl   (ovf_tgl),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata)
  );

  bes_bitram #(.AW(MAX_LOG)) u_ram (
    .wclk  (wr_clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .rclk  (rd_clk),
    .rst   (rst),
    .re    (re),
    .raddr (raddr),
    .q     (rd_dat)
  );

  bes_rd #(.MAX_LOG(MAX_LOG)) u_rd (
    .clk        (rd_clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .size_sel   (size_sel),
    .center     (center),
    .err_clr    (err_clr),
    .wr_gray_a  (wr_gray),
    .ovf_tgl_a  (ovf_tgl),
    .rd_dat     (rd_dat),
    .rd_gray    (rd_gray),
    .re         (re),
    .raddr      (raddr),
    .phase_err  (phase_err),
    .limit_err  (limit_err),
    .limit_full (limit_full)
  );
endmodule

// File: tb/bit_elastic_store_test.sv
module bit_elastic_store_test;
  localparam int MAX_LOG = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_clk = 1'b0, rx_dat = 1'b0, tx_clk = 1'b0, tx_dat = 1'b0;
  logic dir_tx = 1'b0, rd_en = 1'b0, center = 1'b0, err_clr = 1'b0;
  logic [2:0] size_sel = 3'd0;
  logic rd_dat, limit_err, limit_full;
  logic [MAX_LOG:0] phase_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bit_elastic_store #(.MAX_LOG(MAX_LOG)) uut (
    .rst(rst), .rx_clk(rx_clk), .rx_dat(rx_dat), .tx_clk(tx_clk), .tx_dat(tx_dat),
    .dir_tx(dir_tx), .rd_clk(clk), .rd_en(rd_en), .size_sel(size_sel),
    .center(center), .err_clr(err_clr), .rd_dat(rd_dat), .phase_err(phase_err),
    .limit_err(limit_err), .limit_full(limit_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  function automatic logic pat(input int c, input int i);
    return ((i * 7 + c * 3) % 5) < 2;
  endfunction

  task automatic pulse(input bit on_tx, input logic b);
    if (on_tx) begin
      tx_dat = b; #2 tx_clk = 1'b1; #3 tx_clk = 1'b0;
    end else begin
      rx_dat = b; #2 rx_clk = 1'b1; #3 rx_clk = 1'b0;
    end
    #3;
  endtask

  task automatic rd_bit(output logic b);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    b = rd_dat;
  endtask

  initial begin
    #1_500_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    logic b;
    logic last;
    repeat (3) pulse(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9 rd_dat", int'(rd_dat), 0);
    chk("R9 phase_err", int'(phase_err), 0);
    chk("R9 limit_err", int'(limit_err), 0);
    chk("R9 limit_full", int'(limit_full), 0);

    for (int c = 0; c < 8; c++) begin
      int d;
      bit sel;
      d = (c > 4) ? 128 : (8 << c);
      sel = bit'(c % 2);
      @(negedge clk);
      dir_tx = sel;
      size_sel = 3'(c);
      // R3: centering sequence
      center = 1'b1;
      repeat (3) @(negedge clk);
      repeat (3) pulse(sel, 1'b0);
      repeat (4) @(negedge clk);
      center = 1'b0;
      repeat (6) @(negedge clk);
      chk("R3 phase after center", int'(phase_err), d / 2);
      chk("R3 status cleared", int'(limit_full), 0);
      chk("R7 center keeps sticky", int'(limit_err), (c != 0) ? 1 : 0);
      err_clr = 1'b1;
      @(negedge clk) err_clr = 1'b0;
      @(negedge clk);
      chk("R7 cleared by pulse", int'(limit_err), 0);

      // R8: selected pair fills, decoy on the other pair
      for (int i = 0; i < d / 2; i++) begin
        pulse(sel, pat(c, i));
        pulse(!sel, !pat(c, i));
      end
      repeat (5) @(negedge clk);
      chk("R1 R8 full depth fill", int'(phase_err), d);
      chk("R7 no error at top", int'(limit_err), 0);

      // R5: one write too many
      pulse(sel, 1'b1);
      repeat (6) @(negedge clk);
      chk("R5 limit_err", int'(limit_err), 1);
      chk("R5 limit_full", int'(limit_full), 1);
      chk("R5 phase held", int'(phase_err), d);

      // drain the older half, then the pattern (R2)
      for (int i = 0; i < d / 2; i++) rd_bit(b);
      repeat (4) @(negedge clk);
      chk("R4 half drained", int'(phase_err), d / 2);
      for (int i = 0; i < d / 2; i++) begin
        rd_bit(b);
        chk("R2 bit order", int'(b), int'(pat(c, i)));
      end
      last = pat(c, d / 2 - 1);
      repeat (4) @(negedge clk);
      chk("R4 empty", int'(phase_err), 0);
      chk("R5 status kept", int'(limit_full), 1);

      // R6: underrun
      rd_bit(b);
      chk("R6 repeat last bit", int'(b), int'(last));
      @(negedge clk);
      chk("R6 limit_err", int'(limit_err), 1);
      chk("R6 status empty", int'(limit_full), 0);
      chk("R6 phase", int'(phase_err), 0);
    end
    finish_run();
  end
endmodule